// File: doc/BRIEF.md
# Configurable Bits-per-Pixel Pixel Unpacker

This block sits between a frame-buffer fetch engine and a panel timing generator. It accepts 32-bit words over a valid/ready stream and splits each word into pixels at a depth chosen by a 3-bit mode field: 1, 2, 4 or 8 bits per pixel (palette indices), 16 bits per pixel (RGB565 or RGB555), or one pixel per 32-bit container (24-bit or 18-bit colour). Flags choose the pixel order inside a word and whether the four bytes of each word are reversed before unpacking.

The timing generator pulls pixels with its data-enable signal. Colour pixels are converted into 8-bit components and then packed onto the panel bus as 16-bit 565, 18-bit 666 or 24-bit 888. Palette modes drive a separate index output and hold the colour bus black. A pull that finds no word buffered produces a black pixel and sets a sticky underrun flag.

Back-pressure rule: `in_ready` is high when no word is buffered, or when the final pixel of the buffered word is pulled in that same cycle. A new word is therefore taken without a bubble. The producer must hold `in_data` stable while `in_valid` is high and `in_ready` is low. Configuration inputs may change only while no word is buffered.

Top module: `pxu_top`

## Requirements
- R1: Mode codes are 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp, 5=32-bit container. A word is released after exactly 32/bpp pixel pulls, which is 1 pull in mode 5.
- R2: With `cfg_lsb_first`=1, pixel k of a word is bits [k*bpp +: bpp]. With it clear, pixel k is taken from the top: bits [31-k*bpp -: bpp]. In mode 4 this means the low halfword goes first when the flag is set, and the high halfword goes first otherwise.
- R3: With `cfg_byte_swap`=1, the word's byte order is reversed (byte 0 becomes byte 3) before any pixel is extracted.
- R4: In modes 0-3 the pixel field, zero-extended to 8 bits, appears on `pix_index`, and `pix_data` is 0.
- R5: In mode 4 with `cfg_rgb555`=0, the pixel is red[15:11], green[10:5], blue[4:0]. With `cfg_rgb555`=1 it is red[14:10], green[9:5], blue[4:0]. A 5-bit component becomes 6 bits by appending a copy of its MSB. `pix_index` is 0 in colour modes.
- R6: In mode 5 with `cfg_src18`=0, red, green and blue are bits [23:16], [15:8] and [7:0]. With `cfg_src18`=1 they are the 6-bit fields [21:16], [13:8] and [5:0]. Modes 6 and 7 act as mode 5.
- R7: A 6-bit component becomes 8 bits as {c6, c6[5:4]}. `cfg_out_fmt`=0 drives {r[7:3],g[7:2],b[7:3]} on bits [15:0]. `cfg_out_fmt`=1 drives {r[7:2],g[7:2],b[7:2]} on bits [17:0]. Values 2 and 3 drive {r,g,b} on bits [23:0]. Unused upper bits are 0.
- R8: `in_ready` is 1 when no word is held, and also when the last pixel of the held word is pulled in that cycle. It is 0 otherwise. Consecutive words can be drained with `pix_de` high in every cycle and no underrun.
- R9: `pix_data` and `pix_index` update on the clock edge where `pix_de` is high, and hold their value while it is low.
- R10: A pull with no word held drives `pix_data` and `pix_index` to 0 and sets `underrun`. Only reset clears `underrun`.
- R11: After reset `pix_data`, `pix_index` and `underrun` are 0, no word is held and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Depth mode code |
| cfg_rgb555 | input | 1 | Mode 4 uses the 555 layout |
| cfg_src18 | input | 1 | Mode 5 holds 6-bit components |
| cfg_lsb_first | input | 1 | Pixels are taken from the low end of the word first |
| cfg_byte_swap | input | 1 | Reverse the byte order of each word |
| cfg_out_fmt | input | 2 | Panel bus format: 0 = 565, 1 = 666, 2/3 = 888 |
| in_data | input | 32 | Fetched word |
| in_valid | input | 1 | Word is offered |
| in_ready | output | 1 | Word will be taken |
| pix_de | input | 1 | Pixel pull from the timing generator |
| pix_data | output | 24 | Panel colour bus |
| pix_index | output | 8 | Palette index |
| underrun | output | 1 | Sticky pull-without-data flag |

## Verification
`in_ready` is combinational, so the bench reads it one time step after changing `pix_de` in the same low clock phase. A word offered in one cycle is taken at the next rising edge. Each pixel pulled by `pix_de` at a rising edge appears on `pix_data` and `pix_index` after that same edge. The bench sets `pix_de` and samples the previous pixel only at falling edges, so every comparison reads the register one half-cycle after the edge that loaded it. The `underrun` flag is checked at the falling edge after the pull that found no word. Hold is checked one full idle cycle later.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(WORD_W);
  localparam int SH_W    = CNT_W + 1;
  localparam int COMP_W  = 8;
  localparam int OUT_W   = 3 * COMP_W;
  localparam int IDX_W   = 8;
  localparam int FIELD_W = 24;

  localparam logic [2:0] MODE_16 = 3'd4;
  localparam logic [2:0] MODE_32 = 3'd5;
  localparam logic [2:0] LG_MAX  = 3'd5;

  localparam logic [1:0] OFMT_16 = 2'd0;
  localparam logic [1:0] OFMT_18 = 2'd1;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;

  // log2 of bits per pixel; codes 5..7 all mean a full 32-bit container
  function automatic logic [2:0] bpp_log2(input logic [2:0] m);
    return (m >= MODE_32) ? LG_MAX : m;
  endfunction

  // index of the final pixel inside one word
  function automatic logic [CNT_W-1:0] last_index(input logic [2:0] m);
    logic [SH_W-1:0] n;
    n = SH_W'(WORD_W) >> bpp_log2(m);
    return CNT_W'(n - SH_W'(1));
  endfunction

  function automatic logic [5:0] widen5(input logic [4:0] c);
    return {c, c[4]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction
endpackage

// File: rtl/pxu_wordbuf.sv
module pxu_wordbuf
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic              held,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt
);
  logic last;
  logic accept;

  assign last     = (cnt == last_index(mode));
  assign in_ready = !held || (take && last);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      cnt  <= '0;
      word <= '0;
    end else if (accept) begin
      held <= 1'b1;
      cnt  <= '0;
      word <= in_data;
    end else if (take && held) begin
      if (last) begin
        held <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R1: the pixel position never passes the final slot of the word
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (cnt <= last_index(mode)));

  // R8: an accepted word is held from the start position
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (held && cnt == '0 && word == $past(in_data)));

  // R9: without a pull the held word and position are frozen
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !take) |=> (held && $stable(word) && $stable(cnt)));

  // R1: pulling the last pixel with nothing offered empties the buffer
  a_r1_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (held && take && last && !in_valid) |=> !held);
endmodule

// File: rtl/pxu_extract.sv
module pxu_extract
  import pxu_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic [2:0]         mode,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               lsb_first,
  input  logic               byte_swap,
  output logic [FIELD_W-1:0] field
);
  localparam int NB = WORD_W / BYTE_W;

  logic [WORD_W-1:0]  swapped;
  logic [WORD_W-1:0]  ordered;
  logic [2:0]         lg;
  logic [SH_W-1:0]    wid;
  logic [SH_W-1:0]    off;
  logic [SH_W-1:0]    sh;
  logic [FIELD_W-1:0] mask;

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign swapped[BYTE_W*b +: BYTE_W] = word[BYTE_W*(NB-1-b) +: BYTE_W];
  end

  assign ordered = byte_swap ? swapped : word;

  always_comb begin
    lg    = bpp_log2(mode);
    wid   = SH_W'(1) << lg;
    off   = {1'b0, cnt} << lg;
    sh    = lsb_first ? off : (SH_W'(WORD_W) - wid - off);
    mask  = (lg >= LG_MAX) ? '1 : ((FIELD_W'(1) << wid) - FIELD_W'(1));
    field = FIELD_W'(ordered >> sh) & mask;
  end
endmodule

// File: rtl/pxu_color.sv
module pxu_color
  import pxu_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic [2:0]         mode,
  input  logic               rgb555,
  input  logic               src18,
  input  logic [1:0]         out_fmt,
  output logic [OUT_W-1:0]   data,
  output logic [IDX_W-1:0]   index
);
  rgb_t c;

  always_comb begin
    c     = '0;
    index = '0;
    if (mode < MODE_16) begin
      index = field[IDX_W-1:0];
    end else if (mode == MODE_16) begin
      if (rgb555) begin
        c.r = widen6(widen5(field[14:10]));
        c.g = widen6(widen5(field[9:5]));
      end else begin
        c.r = widen6(widen5(field[15:11]));
        c.g = widen6(field[10:5]);
      end
      c.b = widen6(widen5(field[4:0]));
    end else if (src18) begin
      c.r = widen6(field[21:16]);
      c.g = widen6(field[13:8]);
      c.b = widen6(field[5:0]);
    end else begin
      c = field;
    end
  end

  always_comb begin
    case (out_fmt)
      OFMT_16: data = OUT_W'({c.r[7:3], c.g[7:2], c.b[7:3]});
      OFMT_18: data = OUT_W'({c.r[7:2], c.g[7:2], c.b[7:2]});
      default: data = c;
    endcase
  end
endmodule

// File: rtl/pxu_top.sv
module pxu_top
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_rgb555,
  input  logic              cfg_src18,
  input  logic              cfg_lsb_first,
  input  logic              cfg_byte_swap,
  input  logic [1:0]        cfg_out_fmt,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              pix_de,
  output logic [OUT_W-1:0]  pix_data,
  output logic [IDX_W-1:0]  pix_index,
  output logic              underrun
);
  logic               held;
  logic [WORD_W-1:0]  word;
  logic [CNT_W-1:0]   cnt;
  logic [FIELD_W-1:0] field;
  logic [OUT_W-1:0]   c_data;
  logic [IDX_W-1:0]   c_index;

  pxu_wordbuf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_mode),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .take     (pix_de),
    .held     (held),
    .word     (word),
    .cnt      (cnt)
  );

  pxu_extract u_ext (
    .word      (word),
    .mode      (cfg_mode),
    .cnt       (cnt),
    .lsb_first (cfg_lsb_first),
    .byte_swap (cfg_byte_swap),
    .field     (field)
  );

  pxu_color u_col (
    .field   (field),
    .mode    (cfg_mode),
    .rgb555  (cfg_rgb555),
    .src18   (cfg_src18),
    .out_fmt (cfg_out_fmt),
    .data    (c_data),
    .index   (c_index)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_data  <= '0;
      pix_index <= '0;
      underrun  <= 1'b0;
    end else if (pix_de) begin
      if (held) begin
        pix_data  <= c_data;
        pix_index <= c_index;
      end else begin
        pix_data  <= '0;
        pix_index <= '0;
        underrun  <= 1'b1;
      end
    end
  end

  // R10: once raised the flag stays up until reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R10: a pull that finds nothing gives black and raises the flag
  a_r10_empty_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && !held) |=> (underrun && pix_data == '0 && pix_index == '0));

  // R4: palette modes keep the colour bus black
  a_r4_index_black: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && cfg_mode < MODE_16) |=> (pix_data == '0));

  // R5: colour modes keep the index at zero
  a_r5_colour_no_index: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && cfg_mode >= MODE_16) |=> (pix_index == '0));

  // R7: a 16-bit panel leaves the upper byte clear
  a_r7_narrow16: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && cfg_out_fmt == OFMT_16) |=> (pix_data[OUT_W-1:16] == '0));

  // R7: an 18-bit panel leaves the top six bits clear
  a_r7_narrow18: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && cfg_out_fmt == OFMT_18) |=> (pix_data[OUT_W-1:18] == '0));

  // R9: outputs hold while no pull is made
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |=> ($stable(pix_data) && $stable(pix_index)));
endmodule

// File: tb/pxu_top_bench.sv
module pxu_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [2:0]  mode;
    logic        r555;
    logic        s18;
    logic        lsb;
    logic        swp;
    logic [1:0]  fmt;
    logic [31:0] word;
    logic [23:0] data;
    logic [7:0]  idx;
  } vec_t;

  // mode, 555, src18, lsb, swap, fmt, word, first-pixel data, first-pixel index
  localparam vec_t VECS [NVEC] = '{
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h12345678, 24'h000000, 8'h12},
    {3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 32'h12345678, 24'h000000, 8'h78},
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 32'h80000000, 24'h000000, 8'h00},
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 32'h12345678, 24'h000000, 8'h07},
    {3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 32'h12345678, 24'h000000, 8'h08},
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'hC0000000, 24'h000000, 8'h03},
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'hF80007E0, 24'hFF0000, 8'h00},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 32'h00007C1F, 24'h03F03F, 8'h00},
    {3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00A5C3E7, 24'h00A61C, 8'h00},
    {3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 32'h002A1507, 24'hAA551C, 8'h00},
    {3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 32'h00112233, 24'h112233, 8'h00},
    {3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h1234ABCD, 24'h00ABCD, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_mode = '0;
  logic        cfg_rgb555 = 1'b0;
  logic        cfg_src18 = 1'b0;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_byte_swap = 1'b0;
  logic [1:0]  cfg_out_fmt = '0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        pix_de = 1'b0;
  logic [23:0] pix_data;
  logic [7:0]  pix_index;
  logic        underrun;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxu_top u_pxu_top (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_rgb555(cfg_rgb555),
    .cfg_src18(cfg_src18), .cfg_lsb_first(cfg_lsb_first),
    .cfg_byte_swap(cfg_byte_swap), .cfg_out_fmt(cfg_out_fmt),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .pix_de(pix_de), .pix_data(pix_data), .pix_index(pix_index),
    .underrun(underrun)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R4 R2 8bpp msb-first";
      1: return "R2 8bpp lsb-first";
      2: return "R1 1bpp";
      3: return "R3 byte swap 4bpp";
      4: return "R2 4bpp lsb-first";
      5: return "R1 2bpp";
      6: return "R5 565 high half first";
      7: return "R5 555 low half first, R7 18-bit bus";
      8: return "R6 24-bit source, R7 16-bit bus";
      9: return "R6 18-bit source";
      10: return "R6 reserved mode code";
      default: return "R5 565 R7 16-bit bus";
    endcase
  endfunction

  function automatic int bpp_of(input logic [2:0] m);
    if (m >= 3'd5) return 32;
    if (m == 3'd4) return 16;
    return 1 << m;
  endfunction

  function automatic int w5(input int c);
    return c * 2 + c / 16;
  endfunction

  function automatic int w6(input int c);
    return c * 4 + c / 16;
  endfunction

  // expected {index, data} for pixel k of a vector, from the requirements
  function automatic logic [31:0] model(input vec_t v, input int k);
    logic [31:0] w, f;
    int bpp, pos, r, g, b;
    logic [23:0] d;
    w = v.swp ? {v.word[7:0], v.word[15:8], v.word[23:16], v.word[31:24]} : v.word;
    bpp = bpp_of(v.mode);
    pos = v.lsb ? k * bpp : 32 - (k + 1) * bpp;
    f = w >> pos;
    if (bpp < 32) f = f & ((32'd1 << bpp) - 32'd1);
    if (v.mode < 3'd4) return {f[7:0], 24'h0};
    if (v.mode == 3'd4) begin
      if (v.r555) begin
        r = w6(w5(int'((f >> 10) & 32'd31)));
        g = w6(w5(int'((f >> 5) & 32'd31)));
      end else begin
        r = w6(w5(int'((f >> 11) & 32'd31)));
        g = w6(int'((f >> 5) & 32'd63));
      end
      b = w6(w5(int'(f & 32'd31)));
    end else if (v.s18) begin
      r = w6(int'((f >> 16) & 32'd63));
      g = w6(int'((f >> 8) & 32'd63));
      b = w6(int'(f & 32'd63));
    end else begin
      r = int'((f >> 16) & 32'd255);
      g = int'((f >> 8) & 32'd255);
      b = int'(f & 32'd255);
    end
    if (v.fmt == 2'd0) d = 24'((r / 8) * 2048 + (g / 4) * 32 + b / 8);
    else if (v.fmt == 2'd1) d = 24'((r / 4) * 4096 + (g / 4) * 64 + b / 4);
    else d = 24'(r * 65536 + g * 256 + b);
    return {8'h00, d};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    pix_de = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_mode = v.mode;
    cfg_rgb555 = v.r555;
    cfg_src18 = v.s18;
    cfg_lsb_first = v.lsb;
    cfg_byte_swap = v.swp;
    cfg_out_fmt = v.fmt;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    @(negedge clk);
    check("R11 pix_data after reset", 32'(pix_data), 32'h0);
    check("R11 pix_index after reset", 32'(pix_index), 32'h0);
    check("R11 underrun after reset", 32'(underrun), 32'h0);
    check("R11 in_ready after reset", 32'(in_ready), 32'h1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int ppw;
      logic [31:0] exp;
      v = VECS[i];
      ppw = 32 / bpp_of(v.mode);
      set_cfg(v);
      in_data = v.word;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({"R8 ready low while holding, ", vec_tag(i)}, 32'(in_ready), 32'h0);
      pix_de = 1'b1;
      #1;
      check({"R8 ready on pull, ", vec_tag(i)}, 32'(in_ready), 32'(ppw == 1));
      for (int k = 0; k < ppw; k++) begin
        @(negedge clk);
        exp = model(v, k);
        check({"pixel data ", vec_tag(i)}, 32'(pix_data), 32'(exp[23:0]));
        check({"pixel index ", vec_tag(i)}, 32'(pix_index), 32'(exp[31:24]));
        if (k == 0) begin
          check({"table data ", vec_tag(i)}, 32'(pix_data), 32'(v.data));
          check({"table index ", vec_tag(i)}, 32'(pix_index), 32'(v.idx));
        end
        if (k < ppw - 1) begin
          #1;
          check({"R1 R8 ready per pixel, ", vec_tag(i)}, 32'(in_ready), 32'(k + 1 == ppw - 1));
        end else begin
          pix_de = 1'b0;
        end
      end
      @(negedge clk);
      exp = model(v, ppw - 1);
      check({"R9 hold while idle, ", vec_tag(i)}, 32'(pix_data), 32'(exp[23:0]));
      check({"R1 word released, ", vec_tag(i)}, 32'(in_ready), 32'h1);
    end
    check("R10 no underrun during table", 32'(underrun), 32'h0);

    // R8 back-to-back words with continuous pulls
    cfg_mode = 3'd5; cfg_src18 = 1'b0; cfg_out_fmt = 2'd2;
    cfg_lsb_first = 1'b0; cfg_byte_swap = 1'b0;
    in_data = 32'h00A1B2C3; in_valid = 1'b1;
    @(negedge clk);
    in_data = 32'h00D4E5F6; pix_de = 1'b1;
    #1;
    check("R8 ready with last pull", 32'(in_ready), 32'h1);
    @(negedge clk);
    check("R8 stream pixel A", 32'(pix_data), 32'h00A1B2C3);
    in_data = 32'h00010203;
    #1;
    check("R8 ready again next cycle", 32'(in_ready), 32'h1);
    @(negedge clk);
    check("R8 stream pixel B", 32'(pix_data), 32'h00D4E5F6);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 stream pixel C", 32'(pix_data), 32'h00010203);
    pix_de = 1'b0;
    check("R8 no underrun when streaming", 32'(underrun), 32'h0);

    // R10 underrun
    @(negedge clk);
    pix_de = 1'b1;
    @(negedge clk);
    pix_de = 1'b0;
    check("R10 black on empty pull", 32'(pix_data), 32'h0);
    check("R10 zero index on empty pull", 32'(pix_index), 32'h0);
    check("R10 underrun raised", 32'(underrun), 32'h1);
    in_data = 32'h00334455; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; pix_de = 1'b1;
    @(negedge clk);
    pix_de = 1'b0;
    check("R10 good pixel after underrun", 32'(pix_data), 32'h00334455);
    check("R10 underrun stays set", 32'(underrun), 32'h1);

    // R11 reset while holding a partly drained word
    cfg_mode = 3'd3;
    in_data = 32'hCAFEF00D; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; pix_de = 1'b1;
    @(negedge clk);
    pix_de = 1'b0;
    check("R4 index before reset", 32'(pix_index), 32'hCA);
    do_reset();
    @(negedge clk);
    check("R11 ready after mid-word reset", 32'(in_ready), 32'h1);
    check("R11 index cleared", 32'(pix_index), 32'h0);
    check("R11 underrun cleared", 32'(underrun), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule